// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block drives one timer counter from a trigger chosen among eight sources. A 3-bit select field picks the source: four internal triggers coming from other timers, an edge-detected timer input, two filtered timer inputs, or an external trigger. A 3-bit mode field then decides what the chosen trigger does to the counter. It can clear the counter, gate it, start it, or act as its clock.

The counter sits behind a prescaler and wraps at a programmable auto-reload value. It raises a one-cycle update pulse when it wraps or is reinitialised. Trigger edges are found in the block's own clock domain by comparing the selected level with a copy delayed by one cycle. Each rising edge therefore produces at most one count or one clear. Encoder mode codes are accepted but behave as "slave control off". A typical use chains timers: a master's update event or compare waveform feeds an internal trigger input, and this block either divides it further or uses it as a counting window.

Top module: `trig_slave_ctl`

## Requirements
- R1: `trig_sel_i` picks the trigger: 0 to 3 pick `itr_i[0]` to `itr_i[3]`, 4 picks `ti1_edge_i`, 5 picks `ti1_filt_i`, 6 picks `ti2_filt_i`, 7 picks `ext_trig_i`. Activity on any source that is not selected has no effect on the counter.
- R2: With `slave_mode_i` = 0, the prescaler receives one tick per clock while `cen_i` is 1 and none while it is 0. The trigger is ignored.
- R3: Mode codes 1, 2 and 3 behave exactly as mode 0.
- R4: In mode 4 (reset), the counter counts as in mode 0. A rising edge of the trigger clears the counter and the prescaler, and `update_o` is high in the following cycle. A trigger held high does not clear the counter again.
- R5: In mode 5 (gated), ticks occur only in cycles where `cen_i` and the trigger are both 1. When the trigger falls, the count is held, not cleared, and counting resumes from the held value.
- R6: In mode 6 (trigger), a rising trigger edge sets an internal start flag without clearing the counter. From the next cycle on, the counter ticks every clock even if `cen_i` is 0 and the trigger falls. The flag clears when the mode changes away from 6.
- R7: In mode 7 (external clock), each rising trigger edge gives one prescaler tick when `cen_i` is 1. A level that stays high gives only one tick.
- R8: The counter advances once for every `psc_i`+1 prescaler ticks.
- R9: When the counter is at `arr_i` and advances, it goes to 0 and `update_o` is high for exactly the next cycle.
- R10: A `ug_i` strobe clears the counter and the prescaler, overrides any tick in the same cycle, and makes `update_o` high in the following cycle.
- R11: `cnt_en_o` shows the effective enable: `cen_i` in modes 0 to 4 and 7, `cen_i` AND trigger in mode 5, and `cen_i` OR start flag in mode 6.
- R12: After reset, `cnt_o` is 0, `update_o` is 0, and the start flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_i | input | 1 | Counter enable bit |
| ug_i | input | 1 | Software reinitialise/update strobe |
| trig_sel_i | input | 3 | Trigger source select |
| slave_mode_i | input | 3 | Slave mode select |
| itr_i | input | 4 | Internal triggers from other timers |
| ti1_edge_i | input | 1 | Edge-detected timer input 1 |
| ti1_filt_i | input | 1 | Filtered timer input 1 |
| ti2_filt_i | input | 1 | Filtered timer input 2 |
| ext_trig_i | input | 1 | External trigger |
| psc_i | input | PSC_W | Prescaler divide value minus one |
| arr_i | input | CNT_W | Auto-reload value |
| cnt_o | output | CNT_W | Counter value |
| update_o | output | 1 | Update event pulse |
| cnt_en_o | output | 1 | Effective counter enable |

## Verification
The bench builds the block with CNT_W = 8 and PSC_W = 4. These narrow widths keep each vector short. An auto-reload of 3 reaches the wrap and its update pulse within a handful of cycles, and prescaler values of 1 and 2 bring division by two and three, in both internal and external clock modes, within ten edges. Every source select code is driven with a toggling pattern, and mismatched source/select pairs confirm that unselected inputs are ignored. Directed sequences cover gated resume, trigger-mode latching, reset-mode edges and the strobe priority.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  localparam int unsigned TSEL_W  = 3;
  localparam int unsigned NUM_SRC = 2 ** TSEL_W;
  localparam int unsigned NUM_ITR = 4;

  typedef enum logic [2:0] {
    SM_OFF    = 3'd0,
    SM_ENC1   = 3'd1,
    SM_ENC2   = 3'd2,
    SM_ENC3   = 3'd3,
    SM_RESET  = 3'd4,
    SM_GATED  = 3'd5,
    SM_TRIG   = 3'd6,
    SM_EXTCLK = 3'd7
  } slave_mode_e;
endpackage

// File: rtl/tsm_trig_sel.sv
module tsm_trig_sel
  import tsm_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TSEL_W-1:0]   sel_i,
  input  logic [NUM_ITR-1:0]  itr_i,
  input  logic                ti1_edge_i,
  input  logic                ti1_filt_i,
  input  logic                ti2_filt_i,
  input  logic                ext_trig_i,
  output logic                lvl_o,
  output logic                rise_o
);
  logic [NUM_SRC-1:0] src;
  logic               prev_q;

  // internal triggers occupy the low codes, pin sources the high codes
  for (genvar g = 0; g < NUM_ITR; g++) begin : g_itr
    assign src[g] = itr_i[g];
  end
  assign src[NUM_ITR]   = ti1_edge_i;
  assign src[NUM_ITR+1] = ti1_filt_i;
  assign src[NUM_ITR+2] = ti2_filt_i;
  assign src[NUM_ITR+3] = ext_trig_i;

  assign lvl_o  = src[sel_i];
  assign rise_o = lvl_o & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_o;
  end

  // R7
  // no_double_rise_chk
  no_double_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tsm_mode_ctl.sv
module tsm_mode_ctl
  import tsm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  slave_mode_e mode_i,
  input  logic        cen_i,
  input  logic        lvl_i,
  input  logic        rise_i,
  output logic        tick_o,
  output logic        reinit_o,
  output logic        en_o
);
  logic start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                start_q <= 1'b0;
    else if (mode_i != SM_TRIG) start_q <= 1'b0;
    else if (rise_i)            start_q <= 1'b1;
  end

  always_comb begin
    en_o     = cen_i;
    tick_o   = cen_i;
    reinit_o = 1'b0;
    unique case (mode_i)
      SM_RESET:  reinit_o = rise_i;
      SM_GATED: begin
        en_o   = cen_i & lvl_i;
        tick_o = en_o;
      end
      SM_TRIG: begin
        en_o   = cen_i | start_q;
        tick_o = en_o;
      end
      SM_EXTCLK: tick_o = cen_i & rise_i;
      default: ; // off and encoder codes
    endcase
  end

  // R6
  trig_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SM_TRIG && rise_i) |=> (mode_i != SM_TRIG || en_o));

  // R5
  gate_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SM_GATED && !lvl_i) |-> !tick_o);

  // R7
  extclk_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SM_EXTCLK && !rise_i) |-> !tick_o);
endmodule

// File: rtl/tsm_counter.sv
module tsm_counter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             reinit_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             update_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PSC_W-1:0] PSC_ONE = PSC_W'(1);

  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q <= '0;
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (reinit_i) begin
        psc_q <= '0;
        cnt_q <= '0;
        upd_q <= 1'b1;
      end else if (tick_i) begin
        if (psc_q >= psc_i) begin
          psc_q <= '0;
          if (cnt_q >= arr_i) begin
            cnt_q <= '0;
            upd_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_ONE;
          end
        end else begin
          psc_q <= psc_q + PSC_ONE;
        end
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign update_o = upd_q;

  // R10
  reinit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_i |=> (cnt_q == '0 && psc_q == '0 && upd_q));

  // R8
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !reinit_i) |=> $stable(cnt_q));

  // R9
  wrap_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !reinit_i && psc_q >= psc_i && cnt_q >= arr_i) |=> (cnt_q == '0 && upd_q));

  // R9
  no_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !reinit_i) |=> !upd_q);
endmodule

// File: rtl/trig_slave_ctl.sv
module trig_slave_ctl
  import tsm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cen_i,
  input  logic             ug_i,
  input  logic [2:0]       trig_sel_i,
  input  logic [2:0]       slave_mode_i,
  input  logic [3:0]       itr_i,
  input  logic             ti1_edge_i,
  input  logic             ti1_filt_i,
  input  logic             ti2_filt_i,
  input  logic             ext_trig_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             update_o,
  output logic             cnt_en_o
);
  logic trig_lvl, trig_rise, tick, trig_reinit, reinit;

  tsm_trig_sel u_trig_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (trig_sel_i),
    .itr_i      (itr_i),
    .ti1_edge_i (ti1_edge_i),
    .ti1_filt_i (ti1_filt_i),
    .ti2_filt_i (ti2_filt_i),
    .ext_trig_i (ext_trig_i),
    .lvl_o      (trig_lvl),
    .rise_o     (trig_rise)
  );

  tsm_mode_ctl u_mode_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (slave_mode_e'(slave_mode_i)),
    .cen_i    (cen_i),
    .lvl_i    (trig_lvl),
    .rise_i   (trig_rise),
    .tick_o   (tick),
    .reinit_o (trig_reinit),
    .en_o     (cnt_en_o)
  );

  // software strobe and reset-mode edge share the reinit path
  assign reinit = ug_i | trig_reinit;

  tsm_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .reinit_i (reinit),
    .psc_i    (psc_i),
    .arr_i    (arr_i),
    .cnt_o    (cnt_o),
    .update_o (update_o)
  );

  // R4
  reset_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_mode_i == 3'd4 && trig_rise) |=> (cnt_o == '0 && update_o));
endmodule

// File: tb/trig_slave_ctl_tb.sv
module trig_slave_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int PSC_W = 4;

  typedef struct packed {
    logic [2:0]       sel;
    logic [2:0]       mode;
    logic             cen;
    logic [PSC_W-1:0] psc;
    logic [CNT_W-1:0] arr;
    logic [2:0]       src;  // which source the pattern drives
    logic [1:0]       pat;  // 0 low, 1 high, 2 toggle starting high
    logic [7:0]       n;
    logic [CNT_W-1:0] exp;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd0, 1'b1, 4'd0, 8'd200, 3'd0, 2'd2, 8'd10, 8'd10}, // R2 trigger ignored
    '{3'd0, 3'd0, 1'b0, 4'd0, 8'd200, 3'd0, 2'd0, 8'd10, 8'd0},  // R2 cen low
    '{3'd0, 3'd1, 1'b1, 4'd0, 8'd200, 3'd0, 2'd2, 8'd7,  8'd7},  // R3
    '{3'd0, 3'd3, 1'b1, 4'd0, 8'd200, 3'd0, 2'd0, 8'd5,  8'd5},  // R3
    '{3'd0, 3'd5, 1'b1, 4'd0, 8'd200, 3'd0, 2'd1, 8'd10, 8'd10}, // R5
    '{3'd0, 3'd5, 1'b1, 4'd0, 8'd200, 3'd0, 2'd0, 8'd10, 8'd0},  // R5
    '{3'd0, 3'd7, 1'b1, 4'd0, 8'd200, 3'd0, 2'd2, 8'd10, 8'd5},  // R7
    '{3'd0, 3'd7, 1'b1, 4'd0, 8'd200, 3'd0, 2'd1, 8'd10, 8'd1},  // R7 level high
    '{3'd0, 3'd7, 1'b0, 4'd0, 8'd200, 3'd0, 2'd2, 8'd10, 8'd0},  // R7 cen low
    '{3'd0, 3'd4, 1'b1, 4'd0, 8'd200, 3'd0, 2'd2, 8'd10, 8'd1},  // R4 last edge clears
    '{3'd0, 3'd4, 1'b1, 4'd0, 8'd200, 3'd0, 2'd1, 8'd10, 8'd9},  // R4 held level
    '{3'd0, 3'd6, 1'b0, 4'd0, 8'd200, 3'd0, 2'd1, 8'd10, 8'd9},  // R6
    '{3'd0, 3'd6, 1'b0, 4'd0, 8'd200, 3'd0, 2'd2, 8'd10, 8'd9},  // R6 falls, keeps running
    '{3'd1, 3'd7, 1'b1, 4'd0, 8'd200, 3'd1, 2'd2, 8'd10, 8'd5},  // R1
    '{3'd2, 3'd7, 1'b1, 4'd0, 8'd200, 3'd2, 2'd2, 8'd10, 8'd5},  // R1
    '{3'd3, 3'd7, 1'b1, 4'd0, 8'd200, 3'd3, 2'd2, 8'd10, 8'd5},  // R1
    '{3'd4, 3'd7, 1'b1, 4'd0, 8'd200, 3'd4, 2'd2, 8'd10, 8'd5},  // R1
    '{3'd5, 3'd7, 1'b1, 4'd0, 8'd200, 3'd5, 2'd2, 8'd10, 8'd5},  // R1
    '{3'd6, 3'd7, 1'b1, 4'd0, 8'd200, 3'd6, 2'd2, 8'd10, 8'd5},  // R1
    '{3'd7, 3'd7, 1'b1, 4'd0, 8'd200, 3'd7, 2'd2, 8'd10, 8'd5},  // R1
    '{3'd2, 3'd7, 1'b1, 4'd0, 8'd200, 3'd3, 2'd2, 8'd10, 8'd0},  // R1 unselected
    '{3'd5, 3'd5, 1'b1, 4'd0, 8'd200, 3'd4, 2'd1, 8'd10, 8'd0},  // R1 unselected
    '{3'd0, 3'd0, 1'b1, 4'd2, 8'd200, 3'd0, 2'd0, 8'd9,  8'd3},  // R8
    '{3'd0, 3'd7, 1'b1, 4'd1, 8'd200, 3'd0, 2'd2, 8'd10, 8'd2},  // R8 external
    '{3'd0, 3'd0, 1'b1, 4'd0, 8'd3,   3'd0, 2'd0, 8'd6,  8'd2},  // R9
    '{3'd7, 3'd5, 1'b1, 4'd0, 8'd200, 3'd7, 2'd1, 8'd6,  8'd6}   // R5 external source
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cen = 1'b0, ug = 1'b0;
  logic [2:0]       tsel = '0, smode = '0;
  logic [3:0]       itr = '0;
  logic             ti1e = 1'b0, ti1f = 1'b0, ti2f = 1'b0, etr = 1'b0;
  logic [PSC_W-1:0] psc = '0;
  logic [CNT_W-1:0] arr = '0;
  logic [CNT_W-1:0] cnt;
  logic             upd, cen_eff;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_slave_ctl #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cen_i(cen), .ug_i(ug),
    .trig_sel_i(tsel), .slave_mode_i(smode), .itr_i(itr),
    .ti1_edge_i(ti1e), .ti1_filt_i(ti1f), .ti2_filt_i(ti2f), .ext_trig_i(etr),
    .psc_i(psc), .arr_i(arr), .cnt_o(cnt), .update_o(upd), .cnt_en_o(cen_eff)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic drive_src(input logic [2:0] s, input logic v);
    itr = '0; ti1e = 1'b0; ti1f = 1'b0; ti2f = 1'b0; etr = 1'b0;
    case (s)
      3'd4: ti1e = v;
      3'd5: ti1f = v;
      3'd6: ti2f = v;
      3'd7: etr  = v;
      default: itr[s[1:0]] = v;
    endcase
  endtask

  // called at a negedge; returns at the next negedge with the counter cleared
  task automatic start_vec(input logic [2:0] s, input logic [2:0] m, input logic c,
                           input logic [PSC_W-1:0] p, input logic [CNT_W-1:0] a);
    smode = 3'd0; tsel = s; cen = c; psc = p; arr = a; ug = 1'b1;
    drive_src(3'd0, 1'b0);
    @(negedge clk);
    ug = 1'b0; smode = m;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(3);
    // R12 reset state
    check("R12 cnt", int'(cnt), 0);
    check("R12 update", int'(upd), 0);
    rst_n = 1'b1;
    step(1);

    for (int v = 0; v < NV; v++) begin
      start_vec(VECS[v].sel, VECS[v].mode, VECS[v].cen, VECS[v].psc, VECS[v].arr);
      for (int i = 0; i < int'(VECS[v].n); i++) begin
        case (VECS[v].pat)
          2'd1:    drive_src(VECS[v].src, 1'b1);
          2'd2:    drive_src(VECS[v].src, (i % 2) == 0);
          default: drive_src(VECS[v].src, 1'b0);
        endcase
        @(negedge clk);
      end
      check($sformatf("vector %0d", v), int'(cnt), int'(VECS[v].exp));
    end

    // R9 / R10 update timing
    start_vec(3'd0, 3'd0, 1'b1, 4'd0, 8'd3);
    check("R10 update after strobe", int'(upd), 1);
    check("R10 cnt after strobe", int'(cnt), 0);
    step(3);
    check("R9 cnt at arr", int'(cnt), 3);
    check("R9 no update before wrap", int'(upd), 0);
    step(1);
    check("R9 wrap to zero", int'(cnt), 0);
    check("R9 update on wrap", int'(upd), 1);
    step(1);
    check("R9 update one cycle", int'(upd), 0);
    check("R9 count after wrap", int'(cnt), 1);
    ug = 1'b1;
    step(1);
    ug = 1'b0;
    check("R10 strobe beats tick", int'(cnt), 0);
    check("R10 strobe update", int'(upd), 1);

    // R4 update from reset-mode edge
    start_vec(3'd0, 3'd4, 1'b1, 4'd0, 8'd200);
    step(5);
    check("R4 counts", int'(cnt), 5);
    check("R4 no update", int'(upd), 0);
    drive_src(3'd0, 1'b1);
    step(1);
    check("R4 edge clears", int'(cnt), 0);
    check("R4 edge update", int'(upd), 1);
    step(1);
    check("R4 held high no clear", int'(cnt), 1);

    // R5 / R11 gated resume
    start_vec(3'd0, 3'd5, 1'b1, 4'd0, 8'd200);
    drive_src(3'd0, 1'b1);
    #1 check("R11 gated enable high", int'(cen_eff), 1);
    step(4);
    check("R5 gated count", int'(cnt), 4);
    drive_src(3'd0, 1'b0);
    #1 check("R11 gated enable low", int'(cen_eff), 0);
    step(3);
    check("R5 gated hold", int'(cnt), 4);
    drive_src(3'd0, 1'b1);
    step(2);
    check("R5 gated resume", int'(cnt), 6);

    // R6 / R11 trigger start latch
    start_vec(3'd0, 3'd6, 1'b0, 4'd0, 8'd200);
    #1 check("R11 trig enable idle", int'(cen_eff), 0);
    drive_src(3'd0, 1'b1);
    step(1);
    check("R6 no count on edge", int'(cnt), 0);
    check("R11 trig enable latched", int'(cen_eff), 1);
    drive_src(3'd0, 1'b0);
    step(3);
    check("R6 runs after fall", int'(cnt), 3);
    smode = 3'd0;
    step(1);
    check("R6 leave mode stops", int'(cnt), 3);
    check("R6 flag cleared", int'(cen_eff), 0);
    smode = 3'd6;
    step(2);
    check("R6 no restart without edge", int'(cnt), 3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule